// File: doc/BRIEF.md
# External Memory Cycle Stretch Sequencer

This block times the external data-memory accesses of an 8-bit microcontroller core. The core presents one request at a time: a direction flag, an address and, for writes, a data byte. The sequencer puts the address on the memory bus and raises a valid flag. It pulses the read or write strobe for a number of clock cycles set by a 3-bit stretch value, which comes from a clock-control field. It then reports completion with a one-cycle done pulse. A read returns the byte sampled from the memory bus.

Reads and writes follow different width rules. A read holds the address and the read strobe together for stretch+1 cycles. A write holds the address for stretch+2 cycles. Inside that window the write strobe starts one cycle after the address and lasts `max(stretch,1)` cycles, so the two lowest settings both give a one-cycle write strobe.

The controller is a five-state machine:
- `ST_IDLE` waits for a request. The ready output is high only here.
- `ST_RD_STROBE` holds the address and the read strobe.
- `ST_WR_SETUP` drives the address with no strobe for one cycle.
- `ST_WR_STROBE` holds the write strobe.
- `ST_WR_HOLD` keeps the address after the strobe for one cycle. It is skipped when the stretch is 0.

The transitions are named as follows:
- *accept read*: `ST_IDLE`→`ST_RD_STROBE`.
- *accept write*: `ST_IDLE`→`ST_WR_SETUP`.
- *read end*: `ST_RD_STROBE`→`ST_IDLE`, once the captured count is spent.
- *setup end*: `ST_WR_SETUP`→`ST_WR_STROBE`.
- *strobe end*: `ST_WR_STROBE`→`ST_WR_HOLD`, or `ST_WR_STROBE`→`ST_IDLE` when the stretch is 0.
- *hold end*: `ST_WR_HOLD`→`ST_IDLE`.

Top module: `xmem_stretch_seq`

## Requirements
- R1: After reset `req_ready` is 1, and `mem_addr_vld`, `mem_rd`, `mem_wr` and `done` are 0, with `mem_addr` and `mem_wdata` at 0.
- R2: A read accepted with stretch value s drives `mem_addr_vld` and `mem_rd` high together for exactly s+1 consecutive cycles, with `mem_addr` equal to the requested address.
- R3: A write accepted with stretch value s drives `mem_addr_vld` high for exactly s+2 consecutive cycles, with `mem_addr` equal to the requested address.
- R4: The write strobe `mem_wr` lasts 1 cycle when s is 0 or 1, and s cycles when s is 2 to 7.
- R5: The write strobe never rises in the first cycle of the address window. At least one address-only cycle comes before it.
- R6: During every cycle of a write's address window, `mem_wdata` equals the requested write data.
- R7: `done` is high for exactly one cycle, in the cycle right after the address window ends. On a read, `rdata` then holds the byte on `mem_rdata` in the last cycle of the read strobe.
- R8: The stretch value is captured when a request is accepted. A change on `stretch_cfg` during the access does not alter that access's timing.
- R9: A request is accepted only in a cycle where `req_ready` is 1. A request raised while an access is in progress is dropped and produces no further bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stretch_cfg | input | 3 | Stretch value from the clock-control field |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Sequencer idle; a request is taken this cycle |
| mem_addr | output | 16 | Memory address, 0 outside a window |
| mem_addr_vld | output | 1 | Address window active |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data, 0 outside a write window |
| mem_rdata | input | 8 | Read data from memory |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Byte returned by the last read |

## Verification
The assertions assume that `req_valid`, `req_write`, `req_addr` and `stretch_cfg` are settled before the clock edge at which a request may be taken. They also assume that `mem_rdata` reflects the addressed byte while `mem_rd` is high. The bench changes every input only on the falling clock edge. Its memory model drives read data combinationally from the current address during the strobe. A request that arrives while the block is busy, and a stretch change in mid-access, are both raised on a falling edge, so each lands in a whole cycle that the assertions can judge.

// File: rtl/xms_pkg.sv
package xms_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_STROBE,
        ST_WR_SETUP,
        ST_WR_STROBE,
        ST_WR_HOLD
    } xms_state_e;

endpackage

// File: rtl/xms_width_calc.sv
module xms_width_calc #(
    parameter int STR_W = 3
) (
    input  logic [STR_W-1:0] stretch_i,
    output logic [STR_W-1:0] rd_left_o,
    output logic [STR_W-1:0] wr_left_o
);
    // Counts are "cycles remaining after the first", so a strobe of n cycles loads n-1.
    localparam logic [STR_W-1:0] TWO = STR_W'(2);

    always_comb begin
        rd_left_o = stretch_i;
        if (stretch_i < TWO) begin
            wr_left_o = '0;
        end else begin
            wr_left_o = stretch_i - STR_W'(1);
        end
    end

endmodule

// File: rtl/xms_datapath.sv
module xms_datapath #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              capture_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic [ADDR_W-1:0] addr_q_o,
    output logic [DATA_W-1:0] wdata_q_o,
    output logic [DATA_W-1:0] rdata_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q_o  <= '0;
            wdata_q_o <= '0;
            rdata_o   <= '0;
        end else begin
            if (load_i) begin
                addr_q_o  <= addr_i;
                wdata_q_o <= wdata_i;
            end
            if (capture_i) begin
                rdata_o <= mem_rdata_i;
            end
        end
    end

endmodule

// File: rtl/xms_ctrl.sv
module xms_ctrl
    import xms_pkg::*;
#(
    parameter int STR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             start_write_i,
    input  logic [STR_W-1:0] stretch_i,
    output logic             ready_o,
    output logic             addr_vld_o,
    output logic             rd_o,
    output logic             wr_o,
    output logic             wr_win_o,
    output logic             capture_o,
    output logic             done_o
);
    localparam int RUN_W = STR_W + 2;

    xms_state_e       state, state_n;
    logic [STR_W-1:0] cnt, cnt_n;
    logic [STR_W-1:0] stretch_q;
    logic             done_n;
    logic [STR_W-1:0] rd_left, wr_left;

    xms_width_calc #(.STR_W(STR_W)) u_width (
        .stretch_i (stretch_q),
        .rd_left_o (rd_left),
        .wr_left_o (wr_left)
    );

    // next-state logic
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        done_n  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start_i) begin
                    if (start_write_i) begin
                        state_n = ST_WR_SETUP;
                        cnt_n   = '0;
                    end else begin
                        state_n = ST_RD_STROBE;
                        cnt_n   = stretch_i;
                    end
                end
            end
            ST_RD_STROBE: begin
                if (cnt == '0) begin
                    state_n = ST_IDLE;
                    done_n  = 1'b1;
                end else begin
                    cnt_n = cnt - STR_W'(1);
                end
            end
            ST_WR_SETUP: begin
                state_n = ST_WR_STROBE;
                cnt_n   = wr_left;
            end
            ST_WR_STROBE: begin
                if (cnt == '0) begin
                    if (stretch_q == '0) begin
                        state_n = ST_IDLE;
                        done_n  = 1'b1;
                    end else begin
                        state_n = ST_WR_HOLD;
                    end
                end else begin
                    cnt_n = cnt - STR_W'(1);
                end
            end
            ST_WR_HOLD: begin
                state_n = ST_IDLE;
                done_n  = 1'b1;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            stretch_q <= '0;
            done_o    <= 1'b0;
        end else begin
            state  <= state_n;
            cnt    <= cnt_n;
            done_o <= done_n;
            if (state == ST_IDLE && start_i) begin
                stretch_q <= stretch_i;
            end
        end
    end

    // outputs
    always_comb begin
        ready_o    = (state == ST_IDLE);
        addr_vld_o = (state != ST_IDLE);
        rd_o       = (state == ST_RD_STROBE);
        wr_o       = (state == ST_WR_STROBE);
        wr_win_o   = (state == ST_WR_SETUP) || (state == ST_WR_STROBE) || (state == ST_WR_HOLD);
        capture_o  = (state == ST_RD_STROBE) && (cnt == '0);
    end

    // ---------------- checks ----------------
    logic [RUN_W-1:0] rd_run, wr_run, vld_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_run  <= '0;
            wr_run  <= '0;
            vld_run <= '0;
        end else begin
            rd_run  <= rd_o       ? rd_run + RUN_W'(1)  : '0;
            wr_run  <= wr_o       ? wr_run + RUN_W'(1)  : '0;
            vld_run <= addr_vld_o ? vld_run + RUN_W'(1) : '0;
        end
    end

    assert_rd_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_o) |-> $past(rd_run) == RUN_W'($past(stretch_q)));

    assert_wr_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(addr_vld_o) && $past(wr_win_o)) |-> $past(vld_run) == RUN_W'($past(stretch_q)) + RUN_W'(1));

    assert_wr_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_o) |-> $past(wr_run) == (($past(stretch_q) < STR_W'(2)) ? RUN_W'(0) : RUN_W'($past(stretch_q)) - RUN_W'(1)));

    assert_wr_setup_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_o) |-> ($past(addr_vld_o) && $past(wr_win_o)));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_after_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(addr_vld_o) && !addr_vld_o);

    assert_stretch_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_vld_o && $past(addr_vld_o)) |-> $stable(stretch_q));

endmodule

// File: rtl/xmem_stretch_seq.sv
module xmem_stretch_seq #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int STR_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STR_W-1:0]  stretch_cfg,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_addr_vld,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);

    logic              accept;
    logic              wr_win;
    logic              capture;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    assign accept = req_valid && req_ready;

    xms_ctrl #(.STR_W(STR_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (req_valid),
        .start_write_i (req_write),
        .stretch_i     (stretch_cfg),
        .ready_o       (req_ready),
        .addr_vld_o    (mem_addr_vld),
        .rd_o          (mem_rd),
        .wr_o          (mem_wr),
        .wr_win_o      (wr_win),
        .capture_o     (capture),
        .done_o        (done)
    );

    xms_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (accept),
        .addr_i      (req_addr),
        .wdata_i     (req_wdata),
        .capture_i   (capture),
        .mem_rdata_i (mem_rdata),
        .addr_q_o    (addr_q),
        .wdata_q_o   (wdata_q),
        .rdata_o     (rdata)
    );

    assign mem_addr  = mem_addr_vld ? addr_q  : '0;
    assign mem_wdata = wr_win       ? wdata_q : '0;

    assert_busy_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> $stable(addr_q) && $stable(wdata_q));

    assert_rd_has_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> mem_addr_vld && !wr_win);

endmodule

// File: tb/xmem_stretch_seq_bench.sv
`timescale 1ns/1ps
module xmem_stretch_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  stretch_cfg = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready;
    logic [15:0] mem_addr;
    logic        mem_addr_vld;
    logic        mem_rd;
    logic        mem_wr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    logic        done;
    logic [7:0]  rdata;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    xmem_stretch_seq u_xmem_stretch_seq (
        .clk(clk), .rst_n(rst_n), .stretch_cfg(stretch_cfg),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .mem_addr(mem_addr),
        .mem_addr_vld(mem_addr_vld), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done), .rdata(rdata)
    );

    // memory model
    logic [7:0] mem [0:255];
    always @(posedge clk) if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
    assign mem_rdata = mem_rd ? mem[mem_addr[7:0]] : 8'h00;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // vector: {write, stretch, addr, data}
    localparam int NV = 16;
    localparam logic [27:0] VEC [NV] = '{
        {1'b1, 3'd0, 16'h0010, 8'hA1}, {1'b1, 3'd1, 16'h0021, 8'hB2},
        {1'b1, 3'd2, 16'h0032, 8'hC3}, {1'b1, 3'd3, 16'h0043, 8'hD4},
        {1'b1, 3'd4, 16'h0054, 8'hE5}, {1'b1, 3'd5, 16'h1065, 8'h16},
        {1'b1, 3'd6, 16'h2076, 8'h27}, {1'b1, 3'd7, 16'hF087, 8'h38},
        {1'b0, 3'd7, 16'h0010, 8'hA1}, {1'b0, 3'd6, 16'h0021, 8'hB2},
        {1'b0, 3'd5, 16'h0032, 8'hC3}, {1'b0, 3'd4, 16'h0043, 8'hD4},
        {1'b0, 3'd3, 16'h0054, 8'hE5}, {1'b0, 3'd2, 16'h1065, 8'h16},
        {1'b0, 3'd1, 16'h2076, 8'h27}, {1'b0, 3'd0, 16'hF087, 8'h38}
    };

    // One access; optionally change stretch and raise a stray request mid-access.
    task automatic access(input bit wr, input logic [2:0] s, input logic [15:0] a,
                          input logic [7:0] d, input logic [2:0] s_mid, input bit stray);
        int vld = 0, rdn = 0, wrn = 0, cyc = 0;
        bit setup_ok = 1, wd_ok = 1, addr_ok = 1, saw_done = 0, rd_wr_ok = 1;
        int exp_w;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        stretch_cfg = s; req_write = wr; req_addr = a; req_wdata = d; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; stretch_cfg = s_mid;
        while (cyc < 40) begin
            if (done) begin saw_done = 1; break; end
            if (mem_addr_vld) begin
                if (mem_addr != a) addr_ok = 0;
                if (wr && mem_wdata != d) wd_ok = 0;
                if (vld == 0 && mem_wr) setup_ok = 0;
                if (wr && mem_rd) rd_wr_ok = 0;
                if (!wr && (mem_wr || !mem_rd)) rd_wr_ok = 0;
                vld++;
            end
            if (mem_rd) rdn++;
            if (mem_wr) wrn++;
            if (stray && cyc == 1) begin
                req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0010; req_wdata = 8'h5A;
            end else begin
                req_valid = 1'b0;
            end
            cyc++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk(saw_done, "R7 done seen", int'(saw_done), 1);
        chk(addr_ok, "R2/R3 address", int'(addr_ok), 1);
        if (wr) begin
            exp_w = (s < 2) ? 1 : int'(s);
            chk(vld == int'(s) + 2, "R3 write window", vld, int'(s) + 2);
            chk(wrn == exp_w, "R4 write strobe width", wrn, exp_w);
            chk(setup_ok, "R5 address-only first cycle", int'(setup_ok), 1);
            chk(wd_ok, "R6 write data held", int'(wd_ok), 1);
            chk(rd_wr_ok, "R3 no read strobe on write", int'(rd_wr_ok), 1);
        end else begin
            chk(vld == int'(s) + 1, "R2 read window", vld, int'(s) + 1);
            chk(rdn == int'(s) + 1, "R2 read strobe width", rdn, int'(s) + 1);
            chk(rd_wr_ok, "R2 strobe covers window", int'(rd_wr_ok), 1);
            chk(rdata == d, "R7 read data", int'(rdata), int'(d));
        end
        chk(!mem_addr_vld, "R7 window closed at done", int'(mem_addr_vld), 0);
        @(negedge clk);
        chk(!done, "R7 done single cycle", int'(done), 0);
    endtask

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
        chk(!mem_addr_vld && !mem_rd && !mem_wr, "R1 strobes low",
            int'({mem_addr_vld, mem_rd, mem_wr}), 0);
        chk(!done, "R1 done low", int'(done), 0);
        chk(mem_addr == 16'h0 && mem_wdata == 8'h0, "R1 bus zero", int'(mem_addr), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !mem_addr_vld, "R1 idle after release", int'(mem_addr_vld), 0);

        for (int i = 0; i < NV; i++) begin
            access(VEC[i][27], VEC[i][26:24], VEC[i][23:8], VEC[i][7:0], VEC[i][26:24], 1'b0);
        end

        // R8: stretch change mid-access has no effect
        access(1'b0, 3'd5, 16'h0043, 8'hD4, 3'd0, 1'b0);
        access(1'b1, 3'd1, 16'h0099, 8'h3C, 3'd7, 1'b0);
        access(1'b1, 3'd6, 16'h009A, 8'h4D, 3'd0, 1'b0);
        access(1'b0, 3'd0, 16'h009A, 8'h4D, 3'd6, 1'b0);

        // R9: request while busy is dropped
        access(1'b0, 3'd4, 16'h0021, 8'hB2, 3'd4, 1'b1);
        begin
            int extra = 0;
            for (int k = 0; k < 4; k++) begin
                if (mem_addr_vld || mem_wr) extra++;
                @(negedge clk);
            end
            chk(extra == 0, "R9 no bus cycle from busy request", extra, 0);
        end
        access(1'b0, 3'd2, 16'h0010, 8'hA1, 3'd2, 1'b0);

        // back-to-back zero-stretch write then read (R4, R3)
        access(1'b1, 3'd0, 16'h00C0, 8'h81, 3'd0, 1'b0);
        access(1'b0, 3'd0, 16'h00C0, 8'h81, 3'd0, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule